// File: doc/BRIEF.md
# Performance Event Counter and Sample Unit

This block keeps four event counters and one sampled-address register for a processor's performance monitoring. Software reaches them through special-purpose-register numbers on a single access port that carries a privilege level. Supervisor code can read and write every register. User code gets read-only copies of the four counters and of the sampled address.

Counting is gated in two ways. A freeze flag in a control register stops it outright. A two-bit condition field compares the current privilege level and the marked-process flag against a programmed selection. When an increment carries a counter's most significant bit from 0 to 1, the block raises a one-cycle exception request. In the same cycle it stores the effective address of the most recently completed instruction.

Top module: `pm_monitor`

## Requirements
- R1: Counters 1 to 4 are read and written at the supervisor numbers 953, 954, 957 and 958. Their user copies are at 937, 938, 941 and 942, in the same counter order.
- R2: A legal read puts the register value on `rd_data` in the cycle after the request. A user-copy read returns the same value as the supervisor counter. Out of reset every counter is 0, and `rd_data` is 0 except after a legal read.
- R3: The 32-bit sampled address is read and written at 955. Its user copy at 939 returns the same value.
- R4: Any write to 937, 938, 939, 941 or 942 leaves all state unchanged and raises `illegal` for one cycle.
- R5: A user-level access to 952, 953, 954, 955, 957 or 958 performs no write, returns 0 and raises `illegal` for one cycle.
- R6: The control register at 952 holds the freeze flag at bit 31 and the condition field at bits 1:0. The condition field enables counting as follows: 00 always; 01 only for a marked process; 10 only in user mode; 11 only in supervisor mode with an unmarked process.
- R7: While counting is enabled, counter i increments by one for each cycle in which `event_in[i]` is high.
- R8: `pm_exc` is high for exactly one cycle after an increment turns a counter's MSB from 0 to 1. A software write never raises it.
- R9: On that same edge the sampled register takes the effective address of the last completed instruction.
- R10: While the freeze flag is set, no counter increments, the sampled register is not captured, and no exception is raised.
- R11: A read of an unmapped number returns 0 and does not raise `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_user | input | 1 | 1 = access is made at user level |
| acc_addr | input | AW | Special-purpose-register number |
| acc_wdata | input | DW | Write data |
| rd_data | output | DW | Read data, one cycle after the request |
| illegal | output | 1 | Illegal-access pulse, one cycle after the request |
| event_in | input | 4 | Per-counter event pulses |
| cmp_valid | input | 1 | An instruction completed this cycle |
| cmp_ea | input | EA_W | Effective address of the completing instruction |
| msr_user | input | 1 | Processor is in user mode |
| msr_marked | input | 1 | Running process is marked |
| pm_exc | output | 1 | Monitor exception request pulse |

## Verification
A counter in the wrong state shows up at the ports on the next read of either of its two addresses, one cycle after the request. It also shows up as an exception pulse that comes early, late or never when an increment is expected to cross the MSB. A wrong gating decision appears as a count that is off by one after a single qualified pulse. A bad sample capture appears at 955 or 939 on the first read after the overflow edge.

// File: rtl/pm_pkg.sv
package pm_pkg;
   localparam int unsigned NUM_CNT  = 4;
   localparam int unsigned SUP_OFS  = 16;
   localparam int unsigned CNT_MIR_NUM [NUM_CNT] = '{937, 938, 941, 942};
   localparam int unsigned SMP_NUM     = 955;
   localparam int unsigned SMP_MIR_NUM = 939;
   localparam int unsigned CTL_NUM     = 952;

   typedef enum logic [2:0] {
      SPR_NONE, SPR_CNT, SPR_CNT_MIR, SPR_SMP, SPR_SMP_MIR, SPR_CTL
   } spr_kind_e;

   typedef enum logic [1:0] {
      MATCH_ALL = 2'b00, MATCH_MARK = 2'b01, MATCH_USER = 2'b10, MATCH_SUP_UNM = 2'b11
   } match_e;
endpackage

// File: rtl/pm_spr_decode.sv
module pm_spr_decode
   import pm_pkg::*;
#(
   parameter int AW = 10,
   localparam int IW = $clog2(NUM_CNT)
) (
   input  logic [AW-1:0] addr,
   output spr_kind_e     kind,
   output logic [IW-1:0] idx
);
   always_comb begin
      kind = SPR_NONE;
      idx  = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (addr == AW'(CNT_MIR_NUM[i])) begin
            kind = SPR_CNT_MIR;
            idx  = IW'(i);
         end
         if (addr == AW'(CNT_MIR_NUM[i] + SUP_OFS)) begin
            kind = SPR_CNT;
            idx  = IW'(i);
         end
      end
      if (addr == AW'(SMP_NUM))     kind = SPR_SMP;
      if (addr == AW'(SMP_MIR_NUM)) kind = SPR_SMP_MIR;
      if (addr == AW'(CTL_NUM))     kind = SPR_CTL;
   end
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic         msb_rise
);
   logic [W-1:0] nxt;
   assign nxt      = q + W'(1);
   assign msb_rise = inc & ~wr_en & ~q[W-1] & nxt[W-1];

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wdata;
      else if (inc)   q <= nxt;
   end
endmodule

// File: rtl/pm_sample.sv
module pm_sample #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmp_valid,
   input  logic [W-1:0] cmp_ea,
   input  logic         capture,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] last_ea;
   logic [W-1:0] src;
   assign src = cmp_valid ? cmp_ea : last_ea;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_ea <= '0;
         q       <= '0;
      end else begin
         if (cmp_valid) last_ea <= cmp_ea;
         if (wr_en)        q <= wdata;
         else if (capture) q <= src;
      end
   end
endmodule

// File: rtl/pm_monitor.sv
module pm_monitor
   import pm_pkg::*;
#(
   parameter int AW    = 10,
   parameter int DW    = 32,
   parameter int CNT_W = 32,
   parameter int EA_W  = 32,
   localparam int IW   = $clog2(NUM_CNT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic               acc_user,
   input  logic [AW-1:0]      acc_addr,
   input  logic [DW-1:0]      acc_wdata,
   output logic [DW-1:0]      rd_data,
   output logic               illegal,
   input  logic [NUM_CNT-1:0] event_in,
   input  logic               cmp_valid,
   input  logic [EA_W-1:0]    cmp_ea,
   input  logic               msr_user,
   input  logic               msr_marked,
   output logic               pm_exc
);
   if (AW < 10 || CNT_W < 2 || CNT_W > DW || EA_W > DW || DW < 2) begin : g_bad_cfg
      $error("pm_monitor: unsupported width parameters");
   end

   spr_kind_e        kind;
   logic [IW-1:0]    idx;
   logic             wr_ok, illegal_now, priv_only, mirror;
   logic             ctl_frz;
   match_e           ctl_match;
   logic             match_ok, cnt_en;
   logic [CNT_W-1:0] cnt_q [NUM_CNT];
   logic [NUM_CNT-1:0] rise;
   logic [EA_W-1:0]  samp_q;
   logic [DW-1:0]    rd_nxt;

   pm_spr_decode #(.AW(AW)) u_dec (.addr(acc_addr), .kind(kind), .idx(idx));

   assign priv_only   = (kind == SPR_CNT) || (kind == SPR_SMP) || (kind == SPR_CTL);
   assign mirror      = (kind == SPR_CNT_MIR) || (kind == SPR_SMP_MIR);
   assign illegal_now = acc_valid & ((acc_user & priv_only) | (acc_write & mirror));
   assign wr_ok       = acc_valid & acc_write & ~illegal_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_frz   <= 1'b0;
         ctl_match <= MATCH_ALL;
      end else if (wr_ok && kind == SPR_CTL) begin
         ctl_frz   <= acc_wdata[DW-1];
         ctl_match <= match_e'(acc_wdata[1:0]);
      end
   end

   always_comb begin
      case (ctl_match)
         MATCH_MARK:    match_ok = msr_marked;
         MATCH_USER:    match_ok = msr_user;
         MATCH_SUP_UNM: match_ok = ~msr_user & ~msr_marked;
         default:       match_ok = 1'b1;
      endcase
   end
   assign cnt_en = ~ctl_frz & match_ok;

   for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      pm_counter #(.W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n),
         .wr_en(wr_ok && kind == SPR_CNT && idx == IW'(g)),
         .wdata(acc_wdata[CNT_W-1:0]),
         .inc(event_in[g] & cnt_en),
         .q(cnt_q[g]),
         .msb_rise(rise[g])
      );
   end

   pm_sample #(.W(EA_W)) u_smp (
      .clk(clk), .rst_n(rst_n),
      .cmp_valid(cmp_valid), .cmp_ea(cmp_ea),
      .capture(|rise),
      .wr_en(wr_ok && kind == SPR_SMP),
      .wdata(acc_wdata[EA_W-1:0]),
      .q(samp_q)
   );

   always_comb begin
      rd_nxt = '0;
      case (kind)
         SPR_CNT, SPR_CNT_MIR: rd_nxt = DW'(cnt_q[idx]);
         SPR_SMP, SPR_SMP_MIR: rd_nxt = DW'(samp_q);
         SPR_CTL: begin
            rd_nxt[DW-1] = ctl_frz;
            rd_nxt[1:0]  = ctl_match;
         end
         default: rd_nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
         illegal <= 1'b0;
         pm_exc  <= 1'b0;
      end else begin
         rd_data <= (acc_valid & ~acc_write & ~illegal_now) ? rd_nxt : '0;
         illegal <= illegal_now;
         pm_exc  <= |rise;
      end
   end
endmodule

// File: rtl/pm_monitor_chk.sv
module pm_monitor_chk #(
   parameter int DW = 32,
   parameter int W  = 32,
   parameter int EW = 32,
   parameter int NE = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          acc_valid,
   input logic          acc_write,
   input logic [NE-1:0] event_in,
   input logic [DW-1:0] rd_data,
   input logic          illegal,
   input logic          pm_exc,
   input logic          frz,
   input logic [W-1:0]  cnt0,
   input logic [EW-1:0] samp
);
   p_illegal_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $past(acc_valid));
   p_illegal_zero_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> rd_data == '0);
   p_exc_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pm_exc |-> $past(|event_in));
   p_exc_not_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pm_exc |-> !$past(frz));
   p_frozen_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && !(acc_valid && acc_write)) |=> $stable(cnt0));
   p_frozen_smp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && !(acc_valid && acc_write)) |=> $stable(samp));
endmodule

bind pm_monitor pm_monitor_chk #(.DW(DW), .W(CNT_W), .EW(EA_W), .NE(pm_pkg::NUM_CNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .event_in(event_in), .rd_data(rd_data), .illegal(illegal), .pm_exc(pm_exc),
   .frz(ctl_frz), .cnt0(cnt_q[0]), .samp(samp_q)
);

// File: tb/sim_pm_monitor.sv
`timescale 1ns/1ps
module sim_pm_monitor;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        acc_valid = 0, acc_write = 0, acc_user = 0;
   logic [9:0]  acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] rd_data;
   logic        illegal, pm_exc;
   logic [3:0]  event_in = '0;
   logic        cmp_valid = 0;
   logic [31:0] cmp_ea = '0;
   logic        msr_user = 0, msr_marked = 0;
   int errors = 0, checks = 0;
   bit done = 0, due = 0;
   logic [31:0] q_rd[$];
   logic        q_ill[$];
   string       q_tag[$];

   always #4 clk = ~clk;

   pm_monitor u0 (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) due <= acc_valid;
   always @(negedge clk) if (due) begin
      if (q_rd.size() == 0) chk("scoreboard empty", 0, 1);
      else begin
         logic [31:0] er; logic ei; string t;
         er = q_rd.pop_front(); ei = q_ill.pop_front(); t = q_tag.pop_front();
         chk({t, " rd_data"}, rd_data, er);
         chk({t, " illegal"}, {31'b0, illegal}, {31'b0, ei});
      end
   end

   task automatic acc(bit w, bit u, int a, logic [31:0] d, logic [31:0] er, bit ei, string t);
      @(negedge clk);
      acc_valid = 1; acc_write = w; acc_user = u; acc_addr = 10'(a); acc_wdata = d;
      q_rd.push_back(er); q_ill.push_back(ei); q_tag.push_back(t);
      @(negedge clk);
      acc_valid = 0; acc_write = 0; acc_user = 0;
   endtask

   task automatic pulse(int i);
      @(negedge clk); event_in[i] = 1'b1;
      @(negedge clk); event_in = '0;
   endtask

   task automatic complete(logic [31:0] ea);
      @(negedge clk); cmp_valid = 1; cmp_ea = ea;
      @(negedge clk); cmp_valid = 0;
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 reset rd_data", rd_data, 0);
      chk("R2 reset exc", {31'b0, pm_exc}, 0);
      acc(0, 0, 953, 0, 0, 0, "R2 reset counter");
      acc(1, 0, 952, 0, 0, 0, "R6 ctl write");
      acc(1, 0, 953, 5, 0, 0, "R1 write cnt1");
      acc(0, 0, 953, 0, 5, 0, "R1 sup read cnt1");
      acc(0, 1, 937, 0, 5, 0, "R2 user read cnt1");
      repeat (3) pulse(1);
      acc(0, 1, 938, 0, 3, 0, "R7 user read cnt2");
      acc(0, 0, 954, 0, 3, 0, "R1 sup read cnt2");
      pulse(2);
      repeat (2) pulse(3);
      acc(0, 1, 941, 0, 1, 0, "R1 user read cnt3");
      acc(0, 1, 942, 0, 2, 0, "R1 user read cnt4");
      acc(0, 0, 957, 0, 1, 0, "R1 sup read cnt3");
      acc(0, 0, 958, 0, 2, 0, "R1 sup read cnt4");
      acc(1, 1, 937, 99, 0, 1, "R4 user write mirror");
      acc(1, 0, 941, 7, 0, 1, "R4 sup write mirror");
      acc(0, 0, 953, 0, 5, 0, "R4 cnt1 unchanged");
      acc(0, 0, 957, 0, 1, 0, "R4 cnt3 unchanged");
      acc(0, 1, 953, 0, 0, 1, "R5 user read sup cnt");
      acc(1, 1, 953, 77, 0, 1, "R5 user write sup cnt");
      acc(0, 0, 953, 0, 5, 0, "R5 cnt1 unchanged");
      acc(0, 1, 952, 0, 0, 1, "R5 user read ctl");
      acc(1, 0, 955, 32'hCAFE0000, 0, 0, "R3 write sample");
      acc(0, 0, 955, 0, 32'hCAFE0000, 0, "R3 sup read sample");
      acc(0, 1, 939, 0, 32'hCAFE0000, 0, "R3 user read sample");
      acc(1, 1, 939, 1, 0, 1, "R4 write sample mirror");
      acc(1, 1, 955, 1, 0, 1, "R5 user write sample");
      acc(0, 0, 955, 0, 32'hCAFE0000, 0, "R4 sample unchanged");
      acc(0, 0, 100, 0, 0, 0, "R11 unmapped read");
      // condition field
      acc(1, 0, 952, 1, 0, 0, "R6 ctl marked");
      pulse(0); acc(0, 0, 953, 0, 5, 0, "R6 unmarked no count");
      msr_marked = 1; pulse(0); acc(0, 0, 953, 0, 6, 0, "R6 marked counts");
      acc(1, 0, 952, 2, 0, 0, "R6 ctl user");
      msr_marked = 0; pulse(0); acc(0, 0, 953, 0, 6, 0, "R6 sup no count");
      msr_user = 1; pulse(0); acc(0, 0, 953, 0, 7, 0, "R6 user counts");
      acc(1, 0, 952, 3, 0, 0, "R6 ctl sup unmarked");
      msr_user = 0; pulse(0); acc(0, 0, 953, 0, 8, 0, "R6 sup unmarked counts");
      msr_marked = 1; pulse(0); acc(0, 0, 953, 0, 8, 0, "R6 sup marked no count");
      msr_user = 1; msr_marked = 0; pulse(0); acc(0, 0, 953, 0, 8, 0, "R6 user no count");
      acc(0, 0, 952, 0, 3, 0, "R6 ctl readback");
      msr_user = 0;
      acc(1, 0, 952, 0, 0, 0, "R6 ctl always");
      // overflow
      acc(1, 0, 953, 32'h7FFFFFFF, 0, 0, "R8 preload");
      chk("R8 no exc on write", {31'b0, pm_exc}, 0);
      complete(32'h10000040);
      pulse(0);
      chk("R8 exc raised", {31'b0, pm_exc}, 1);
      @(negedge clk);
      chk("R8 exc one cycle", {31'b0, pm_exc}, 0);
      acc(0, 0, 955, 0, 32'h10000040, 0, "R9 sample captured");
      acc(0, 0, 953, 0, 32'h80000000, 0, "R8 counter wrapped msb");
      acc(1, 0, 954, 32'h80000000, 0, 0, "R8 write msb");
      chk("R8 no exc on msb write", {31'b0, pm_exc}, 0);
      // freeze
      acc(1, 0, 953, 32'h7FFFFFFF, 0, 0, "R10 preload");
      acc(1, 0, 952, 32'h80000000, 0, 0, "R10 freeze");
      complete(32'h20000080);
      pulse(0);
      chk("R10 no exc frozen", {31'b0, pm_exc}, 0);
      pulse(1);
      acc(0, 0, 953, 0, 32'h7FFFFFFF, 0, "R10 cnt1 held");
      acc(0, 0, 954, 0, 32'h80000000, 0, "R10 cnt2 held");
      acc(0, 0, 955, 0, 32'h10000040, 0, "R10 sample held");
      acc(0, 0, 952, 0, 32'h80000000, 0, "R6 freeze readback");
      repeat (2) @(negedge clk);
      chk("scoreboard drained", q_rd.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule